// File: doc/BRIEF.md
# Two-Group Interrupt CPU Interface

This block sits between a set of interrupt sources and one processor. It keeps a pending flag and an active flag for each source. Each source has a configurable priority and a group bit. Every cycle it picks the best waiting interrupt: pending, not active, with the numerically smallest priority, and the lowest ID when priorities are equal. It compares that choice with a running priority. The running priority comes from two per-group bitmaps of priorities that are currently being serviced. If the choice wins, one of two request lines is raised: the fast line for group 0 or the normal line for group 1.

Software talks to the block through one port set per group: a peek value, an acknowledge request with a one-cycle response, and an end-of-interrupt strobe carrying an ID. The selection can change between the moment a line rises and the moment the handler acknowledges. When the winner now belongs to the other group, the acknowledge yields the spurious ID 1023 and leaves all state untouched. The handler can return and take the other line instead.

Acknowledge and end-of-interrupt are single-cycle control strobes with no back-pressure: a response always appears exactly one cycle after its request and is never held.

Top module: `intc_cpu_if`

## Requirements
- R1: The selected interrupt is the pending, non-active source with the smallest priority value; equal priorities go to the lower source ID (source index i carries ID i).
- R2: The fast line `fiq_o` is high only for a signalled group-0 selection and `irq_o` only for a signalled group-1 selection; never both.
- R3: A selection is signalled only when its priority is strictly smaller than the running priority; otherwise both lines stay low.
- R4: Peek port 0 shows the selected ID when the selection is group 0, else 1023 (0x3FF); peek port 1 does the same for group 1. The peek does not depend on the running priority.
- R5: An acknowledge on a group's port when that group has no signalled selection returns ID 1023 one cycle later and changes no pending, active or bitmap state.
- R6: A valid acknowledge returns the selected ID one cycle later, clears its pending flag, sets its active flag and sets bit `priority` of that group's bitmap (priority 12 gives 0x1000).
- R7: Selection is re-evaluated every cycle; a trigger pulse makes its source pending on the next clock edge, and a better source replaces the earlier choice, moving the request from one line to the other if the group differs.
- R8: End of interrupt on a group's port clears the lowest set bit of that group's bitmap and clears the active flag of the given ID, so a blocked or retriggered source can be selected again.
- R9: The running priority is the index of the lowest set bit across both bitmaps, or 0xFF when both are empty.
- R10: After reset nothing is pending or active, both bitmaps are zero, the running priority is 0xFF, both lines are low and both peeks read 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_trig | input | NUM_SRC | One-cycle pulse per source that sets its pending flag |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, source i in bits [i*PRIO_W +: PRIO_W] |
| src_grp | input | NUM_SRC | Group of each source (0 fast, 1 normal) |
| fiq_o | output | 1 | Fast request line, group 0 |
| irq_o | output | 1 | Normal request line, group 1 |
| hppi0_id | output | 10 | Group-0 peek of the selected ID or 1023 |
| hppi1_id | output | 10 | Group-1 peek of the selected ID or 1023 |
| ack0_req | input | 1 | Group-0 acknowledge strobe |
| ack0_rsp_valid | output | 1 | Group-0 acknowledge response valid, one cycle after the strobe |
| ack0_rsp_id | output | 10 | Group-0 acknowledged ID or 1023 |
| ack1_req | input | 1 | Group-1 acknowledge strobe |
| ack1_rsp_valid | output | 1 | Group-1 acknowledge response valid |
| ack1_rsp_id | output | 10 | Group-1 acknowledged ID or 1023 |
| eoi0_valid | input | 1 | Group-0 end-of-interrupt strobe |
| eoi0_id | input | 10 | ID whose active flag the group-0 strobe clears |
| eoi1_valid | input | 1 | Group-1 end-of-interrupt strobe |
| eoi1_id | input | 10 | ID whose active flag the group-1 strobe clears |
| apr0 | output | 2**PRIO_W | Group-0 active-priority bitmap |
| apr1 | output | 2**PRIO_W | Group-1 active-priority bitmap |
| running_prio | output | 8 | Running priority, 0xFF when idle |

## Verification
The bench builds the block with 32 sources and 5-bit priorities. At that size a source numbered 27 exists alongside lower-numbered ones, so the case of a fast request pre-empted by a better normal-group source can be replayed with priorities 16 and 12. The full 32-bit bitmaps are exercised, so nested service at two priority levels of one group shows the lowest-bit drop order. Equal priorities on sources of different groups reach the ID tie-break.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int RP_W = 8;
  localparam logic [RP_W-1:0] RP_IDLE = 8'hFF;
  localparam int NUM_GRP = 2;
endpackage

// File: rtl/intc_src_state.sv
module intc_src_state
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig,
  input  logic               take,
  input  logic [ID_W-1:0]    take_id,
  input  logic               done0,
  input  logic [ID_W-1:0]    done0_id,
  input  logic               done1,
  input  logic [ID_W-1:0]    done1_id,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] act
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit_take;
    logic hit_done;
    assign hit_take = take && (take_id == ID_W'(i));
    assign hit_done = (done0 && (done0_id == ID_W'(i))) ||
                      (done1 && (done1_id == ID_W'(i)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        act[i]  <= 1'b0;
      end else begin
        pend[i] <= (pend[i] && !hit_take) || trig[i];
        act[i]  <= (act[i] && !hit_done) || hit_take;
      end
    end
  end
endmodule

// File: rtl/intc_select.sv
module intc_select
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [NUM_SRC-1:0]        grp,
  output logic                      sel_valid,
  output logic [ID_W-1:0]           sel_id,
  output logic [PRIO_W-1:0]         sel_prio,
  output logic                      sel_grp
);
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = SPURIOUS_ID;
    sel_prio  = '1;
    sel_grp   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!sel_valid || (prio[i*PRIO_W +: PRIO_W] < sel_prio))) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        sel_prio  = prio[i*PRIO_W +: PRIO_W];
        sel_grp   = grp[i];
      end
    end
  end
endmodule

// File: rtl/intc_apr.sv
module intc_apr #(
  parameter int PRIO_W = 5,
  localparam int APR_W = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [PRIO_W-1:0] set_prio,
  input  logic              drop,
  output logic [APR_W-1:0]  bitmap
);
  logic [APR_W-1:0] after_drop;
  logic [APR_W-1:0] nxt;

  always_comb begin
    after_drop = drop ? (bitmap & (bitmap - APR_W'(1))) : bitmap;
    nxt        = after_drop;
    if (set_en) nxt[set_prio] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bitmap <= '0;
    else        bitmap <= nxt;
  end
endmodule

// File: rtl/intc_cpu_if.sv
module intc_cpu_if
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  localparam int APR_W  = 1 << PRIO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_trig,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC-1:0]        src_grp,
  output logic                      fiq_o,
  output logic                      irq_o,
  output logic [9:0]                hppi0_id,
  output logic [9:0]                hppi1_id,
  input  logic                      ack0_req,
  output logic                      ack0_rsp_valid,
  output logic [9:0]                ack0_rsp_id,
  input  logic                      ack1_req,
  output logic                      ack1_rsp_valid,
  output logic [9:0]                ack1_rsp_id,
  input  logic                      eoi0_valid,
  input  logic [9:0]                eoi0_id,
  input  logic                      eoi1_valid,
  input  logic [9:0]                eoi1_id,
  output logic [APR_W-1:0]          apr0,
  output logic [APR_W-1:0]          apr1,
  output logic [7:0]                running_prio
);
  logic [NUM_SRC-1:0] pend, act;
  logic               sel_valid, sel_grp;
  logic [ID_W-1:0]    sel_id;
  logic [PRIO_W-1:0]  sel_prio;
  logic               signal_ok;

  logic [NUM_GRP-1:0] ack_req_v, eoi_v, grp_match, fire, rsp_valid_q;
  logic [ID_W-1:0]    peek_a   [NUM_GRP];
  logic [ID_W-1:0]    rsp_id_q [NUM_GRP];
  logic [APR_W-1:0]   apr_a    [NUM_GRP];
  logic [APR_W-1:0]   apr_all;

  assign ack_req_v = {ack1_req, ack0_req};
  assign eoi_v     = {eoi1_valid, eoi0_valid};

  intc_src_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst_n(rst_n), .trig(src_trig),
    .take(|fire), .take_id(sel_id),
    .done0(eoi0_valid), .done0_id(eoi0_id),
    .done1(eoi1_valid), .done1_id(eoi1_id),
    .pend(pend), .act(act)
  );

  intc_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
    .cand(pend & ~act), .prio(src_prio), .grp(src_grp),
    .sel_valid(sel_valid), .sel_id(sel_id),
    .sel_prio(sel_prio), .sel_grp(sel_grp)
  );

  assign apr_all = apr_a[0] | apr_a[1];

  always_comb begin
    running_prio = RP_IDLE;
    for (int i = APR_W - 1; i >= 0; i--) begin
      if (apr_all[i]) running_prio = 8'(i);
    end
  end

  assign signal_ok = sel_valid && (8'(sel_prio) < running_prio);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_match[g] = sel_valid && (sel_grp == 1'(g));
    assign peek_a[g]    = grp_match[g] ? sel_id : SPURIOUS_ID;
    assign fire[g]      = ack_req_v[g] && grp_match[g] && signal_ok;

    intc_apr #(.PRIO_W(PRIO_W)) u_apr (
      .clk(clk), .rst_n(rst_n),
      .set_en(fire[g]), .set_prio(sel_prio),
      .drop(eoi_v[g]), .bitmap(apr_a[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid_q[g] <= 1'b0;
        rsp_id_q[g]    <= SPURIOUS_ID;
      end else begin
        rsp_valid_q[g] <= ack_req_v[g];
        if (ack_req_v[g]) rsp_id_q[g] <= fire[g] ? sel_id : SPURIOUS_ID;
      end
    end
  end

  assign fiq_o          = signal_ok && grp_match[0];
  assign irq_o          = signal_ok && grp_match[1];
  assign hppi0_id       = peek_a[0];
  assign hppi1_id       = peek_a[1];
  assign ack0_rsp_valid = rsp_valid_q[0];
  assign ack0_rsp_id    = rsp_id_q[0];
  assign ack1_rsp_valid = rsp_valid_q[1];
  assign ack1_rsp_id    = rsp_id_q[1];
  assign apr0           = apr_a[0];
  assign apr1           = apr_a[1];
endmodule

// File: rtl/intc_cpu_if_chk.sv
module intc_cpu_if_chk #(
  parameter int PRIO_W = 5,
  localparam int APR_W = 1 << PRIO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fiq_o,
  input logic             irq_o,
  input logic [9:0]       hppi0_id,
  input logic [9:0]       hppi1_id,
  input logic             ack0_req,
  input logic             ack0_rsp_valid,
  input logic [9:0]       ack0_rsp_id,
  input logic             eoi0_valid,
  input logic [APR_W-1:0] apr0,
  input logic [APR_W-1:0] apr1,
  input logic [7:0]       running_prio
);
  logic [APR_W-1:0] both;
  logic [APR_W-1:0] below;
  assign both  = apr0 | apr1;
  assign below = (APR_W'(1) << running_prio[PRIO_W-1:0]) - APR_W'(1);

  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(fiq_o && irq_o));

  a_r2_fiq_has_peek: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> hppi0_id != 10'd1023);

  a_r4_peek_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    !(hppi0_id != 10'd1023 && hppi1_id != 10'd1023));

  a_r5_wrong_group_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0_req && hppi0_id == 10'd1023 && !eoi0_valid) |=>
      (ack0_rsp_valid && ack0_rsp_id == 10'd1023 && $stable(apr0)));

  a_r6_ack_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0_req && fiq_o && !eoi0_valid) |=>
      (ack0_rsp_id != 10'd1023 && $countones(apr0) == $countones($past(apr0)) + 1));

  a_r8_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi0_valid && !ack0_req && apr0 != '0) |=>
      $countones(apr0) + 1 == $countones($past(apr0)));

  a_r9_idle_value: assert property (@(posedge clk) disable iff (!rst_n)
    (both == '0) |-> running_prio == 8'hFF);

  a_r9_lowest_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (both != '0) |-> (both[running_prio[PRIO_W-1:0]] && (both & below) == '0));
endmodule

bind intc_cpu_if intc_cpu_if_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_o(fiq_o), .irq_o(irq_o),
  .hppi0_id(hppi0_id), .hppi1_id(hppi1_id),
  .ack0_req(ack0_req), .ack0_rsp_valid(ack0_rsp_valid), .ack0_rsp_id(ack0_rsp_id),
  .eoi0_valid(eoi0_valid), .apr0(apr0), .apr1(apr1), .running_prio(running_prio)
);

// File: tb/intc_cpu_if_bench.sv
module intc_cpu_if_bench;
  localparam int N  = 32;
  localparam int PW = 5;
  localparam int AW = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    src_trig = '0;
  logic [N*PW-1:0] src_prio;
  logic [N-1:0]    src_grp;
  logic fiq_o, irq_o;
  logic [9:0] hppi0_id, hppi1_id;
  logic ack0_req = 1'b0, ack1_req = 1'b0;
  logic ack0_rsp_valid, ack1_rsp_valid;
  logic [9:0] ack0_rsp_id, ack1_rsp_id;
  logic eoi0_valid = 1'b0, eoi1_valid = 1'b0;
  logic [9:0] eoi0_id = '0, eoi1_id = '0;
  logic [AW-1:0] apr0, apr1;
  logic [7:0] running_prio;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_cpu_if #(.NUM_SRC(N), .PRIO_W(PW)) u_intc_cpu_if (.*);

  // {trigger source[4:0], expected ID[9:0], fast line, normal line}
  localparam logic [16:0] VEC [5] = '{
    {5'd3,  10'd3,  1'b0, 1'b1},
    {5'd27, 10'd27, 1'b1, 1'b0},
    {5'd30, 10'd27, 1'b1, 1'b0},
    {5'd9,  10'd9,  1'b1, 1'b0},
    {5'd5,  10'd5,  1'b0, 1'b1}
  };

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse_src(int id);
    src_trig[id] = 1'b1;
    step();
    src_trig = '0;
  endtask

  task automatic ack(int g);
    if (g == 0) ack0_req = 1'b1; else ack1_req = 1'b1;
    step();
    ack0_req = 1'b0; ack1_req = 1'b0;
  endtask

  task automatic eoi(int g, int id);
    if (g == 0) begin eoi0_valid = 1'b1; eoi0_id = 10'(id); end
    else        begin eoi1_valid = 1'b1; eoi1_id = 10'(id); end
    step();
    eoi0_valid = 1'b0; eoi1_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      src_prio[i*PW +: PW] = 5'd31;
      src_grp[i] = 1'b0;
    end
    src_prio[27*PW +: PW] = 5'd16; src_grp[27] = 1'b0;
    src_prio[30*PW +: PW] = 5'd16; src_grp[30] = 1'b1;
    src_prio[9*PW +: PW]  = 5'd12; src_grp[9]  = 1'b0;
    src_prio[5*PW +: PW]  = 5'd12; src_grp[5]  = 1'b1;
    src_prio[3*PW +: PW]  = 5'd20; src_grp[3]  = 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 fiq", fiq_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 peek0", hppi0_id, 1023);
    chk("R10 peek1", hppi1_id, 1023);
    chk("R10 apr0", apr0, 0);
    chk("R10 apr1", apr1, 0);
    chk("R10 running", running_prio, 8'hFF);

    // R1/R2/R4/R7 table: cumulative triggers, selection after each
    foreach (VEC[k]) begin
      pulse_src(int'(VEC[k][16:12]));
      chk("R1 selection", VEC[k][1] ? hppi0_id : hppi1_id, VEC[k][11:2]);
      chk("R2 fiq", fiq_o, VEC[k][1]);
      chk("R2 irq", irq_o, VEC[k][0]);
      chk("R4 other peek", VEC[k][1] ? hppi1_id : hppi0_id, 1023);
    end

    // Directed: fast request overtaken by better normal-group source
    do_reset();
    pulse_src(27);
    chk("R2 fiq for 27", fiq_o, 1);
    chk("R4 peek0 27", hppi0_id, 27);
    pulse_src(5);
    chk("R7 fiq dropped", fiq_o, 0);
    chk("R7 irq raised", irq_o, 1);
    chk("R4 peek0 spurious", hppi0_id, 1023);
    chk("R4 peek1 5", hppi1_id, 5);
    ack(0);
    chk("R5 rsp valid", ack0_rsp_valid, 1);
    chk("R5 rsp id", ack0_rsp_id, 1023);
    chk("R5 apr0 kept", apr0, 0);
    chk("R5 apr1 kept", apr1, 0);
    chk("R5 selection kept", hppi1_id, 5);
    ack(1);
    chk("R6 rsp id", ack1_rsp_id, 5);
    chk("R6 apr1 bit12", apr1, 32'h0000_1000);
    chk("R9 running 12", running_prio, 12);
    chk("R4 peek ignores running", hppi0_id, 27);
    chk("R3 fiq blocked", fiq_o, 0);
    chk("R3 irq idle", irq_o, 0);
    ack(0);
    chk("R5 blocked ack id", ack0_rsp_id, 1023);
    chk("R5 blocked ack apr0", apr0, 0);
    eoi(1, 5);
    chk("R8 apr1 cleared", apr1, 0);
    chk("R9 running idle", running_prio, 8'hFF);
    chk("R8 fiq released", fiq_o, 1);
    ack(0);
    chk("R6 rsp 27", ack0_rsp_id, 27);
    chk("R6 apr0 bit16", apr0, 32'h0001_0000);
    chk("R9 running 16", running_prio, 16);
    pulse_src(27);
    chk("R1 active excluded", hppi0_id, 1023);
    chk("R1 no line", fiq_o, 0);
    pulse_src(9);
    chk("R3 preempt fiq", fiq_o, 1);
    chk("R3 preempt id", hppi0_id, 9);
    ack(0);
    chk("R6 rsp 9", ack0_rsp_id, 9);
    chk("R6 apr0 nested", apr0, 32'h0001_1000);
    chk("R9 running nested", running_prio, 12);
    eoi(0, 9);
    chk("R8 lowest bit dropped", apr0, 32'h0001_0000);
    chk("R9 running back 16", running_prio, 16);
    chk("R8 27 still active", hppi0_id, 1023);
    eoi(0, 27);
    chk("R8 apr0 empty", apr0, 0);
    chk("R9 idle again", running_prio, 8'hFF);
    chk("R8 retrigger selected", hppi0_id, 27);
    chk("R8 retrigger fiq", fiq_o, 1);

    summary();
  end
endmodule